// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sits between a host and a battery-backed static RAM. It watches two comparator flags. The first says the supply is above the power-fail threshold. The second says the supply is above the lower switchover threshold. From these flags it decides whether the host's chip-enable, write-enable and output-enable strobes may reach the RAM. While the supply is healthy and no recovery hold is pending, the strobes pass through unchanged and follow the usual asynchronous SRAM truth table.

When the supply sags below the power-fail threshold, the block waits a programmable number of clock cycles and then locks the RAM. A write that started before the sag may finish inside that window. A write that is still running when the window closes is cut off. If the supply falls further, below the switchover threshold, the block raises a battery-select signal for an external power switch. On the way back up, the block first drops battery select. Once the supply clears the power-fail threshold, it keeps the RAM locked for a second, much longer programmable hold before releasing it. The flag combination "above power-fail but below switchover" cannot occur on a real ramp, so it is treated as a fault and the block goes to the safest state.

Top module: `supply_guard`

## Requirements
- R1: During reset and after it, the RAM is locked (write-protect flag high, battery select low). With both supply flags high it is released exactly REC_DLY_CYC cycles after the first clock edge following reset release.
- R2: When unlocked, RAM chip enable and output enable equal the host's. Output high-impedance is requested when the host chip enable is high, the host output enable is high, or the host write enable is low. In the unlocked idle state, host write enable passes through unchanged.
- R3: After the power-fail flag goes low in the idle state, the write-protect flag stays low for exactly PF_DLY_CYC cycles after the first edge that sees the flag low, and is high on the next cycle.
- R4: While locked, RAM chip enable, write enable and output enable are all held high and output high-impedance is requested, whatever the host drives.
- R5: Battery select is high on every cycle after an edge that sampled the switchover flag low. It drops on the first edge that samples the switchover flag high again. If the power-fail flag is then still low, the block returns to the locked state.
- R6: When the power-fail flag returns high while locked or on battery, the lock holds for REC_DLY_CYC cycles after the first edge that sees both flags high, then releases.
- R7: If the power-fail flag returns high during the protect delay, the block goes back to the idle state without ever raising the write-protect flag.
- R8: A host write (chip enable and write enable both low) that is active on the edge that starts the protect delay keeps passing write enable until it ends. A write that begins during the delay is blocked: RAM write enable stays high.
- R9: A write still active when the protect delay expires has its RAM write enable forced high from that cycle onward.
- R10: Switchover flag low with the power-fail flag high locks the RAM and raises battery select on the next edge.
- R11: A power-fail flag drop during the recovery hold returns the block to the locked state. A later return of the flag restarts the full hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pfOk | input | 1 | Supply above power-fail threshold |
| soOk | input | 1 | Supply above switchover threshold |
| hostCeN | input | 1 | Host chip enable, active low |
| hostWeN | input | 1 | Host write enable, active low |
| hostOeN | input | 1 | Host output enable, active low |
| ramCeN | output | 1 | Gated chip enable to RAM |
| ramWeN | output | 1 | Gated write enable to RAM |
| ramOeN | output | 1 | Gated output enable to RAM |
| batSel | output | 1 | Select battery as RAM supply |
| wrProt | output | 1 | RAM is write-protected |
| outHiZ | output | 1 | Request RAM data outputs in high impedance |

## Verification
At the defaults, the delays are tens of thousands to millions of cycles. The bench therefore builds the block with a protect delay of 8 cycles and a recovery hold of 12 cycles. With these values every boundary can be counted cycle by cycle. The first and last cycle of each delay can be checked exactly. A write can be kept alive across the whole protect window or ended halfway. The block can also be sent into a restarted recovery, all within a short run.

// File: rtl/supply_guard_pkg.sv
`timescale 1ns/1ps
package supply_guard_pkg;

  typedef enum logic [2:0] {
    SUP_IDLE    = 3'd0,
    SUP_PFWAIT  = 3'd1,
    SUP_LOCKED  = 3'd2,
    SUP_BATTERY = 3'd3,
    SUP_RECOVER = 3'd4
  } supState_t;

  // control -> datapath strobe bundle
  typedef struct packed {
    logic blockAll;
    logic allowWe;
  } gateCtl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/supply_guard_ctrl.sv
`timescale 1ns/1ps
module supply_guard_ctrl
  import supply_guard_pkg::*;
#(
  parameter int PF_DLY_CYC  = 20000,
  parameter int REC_DLY_CYC = 16000000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pfOk,
  input  logic     soOk,
  input  logic     hostCeN,
  input  logic     hostWeN,
  output gateCtl_t gateCtl,
  output logic     batSel,
  output logic     wrProt
);

  localparam int CNT_W = $clog2(maxOf(PF_DLY_CYC, REC_DLY_CYC) + 1);
  localparam logic [CNT_W-1:0] PF_LAST  = CNT_W'(PF_DLY_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_DLY_CYC - 1);

  supState_t        st, stNext;
  logic [CNT_W-1:0] cnt;
  logic             loadCnt;
  logic             inDelay;
  logic             wrHold;
  logic             hostWr;

  assign hostWr  = !hostCeN && !hostWeN;
  assign inDelay = (st == SUP_PFWAIT) || (st == SUP_RECOVER);

  always_comb begin
    stNext  = st;
    loadCnt = 1'b0;
    if (!soOk) begin
      stNext = SUP_BATTERY;
    end else begin
      case (st)
        SUP_IDLE: begin
          if (!pfOk) begin
            stNext  = SUP_PFWAIT;
            loadCnt = 1'b1;
          end
        end
        SUP_PFWAIT: begin
          if (pfOk)                stNext = SUP_IDLE;
          else if (cnt == PF_LAST) stNext = SUP_LOCKED;
        end
        SUP_LOCKED: begin
          if (pfOk) begin
            stNext  = SUP_RECOVER;
            loadCnt = 1'b1;
          end
        end
        SUP_BATTERY: begin
          if (pfOk) begin
            stNext  = SUP_RECOVER;
            loadCnt = 1'b1;
          end else begin
            stNext = SUP_LOCKED;
          end
        end
        SUP_RECOVER: begin
          if (!pfOk)                stNext = SUP_LOCKED;
          else if (cnt == REC_LAST) stNext = SUP_IDLE;
        end
        default: stNext = SUP_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= SUP_LOCKED;
      cnt    <= '0;
      wrHold <= 1'b0;
    end else begin
      st <= stNext;
      if (loadCnt || !inDelay) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
      case (st)
        SUP_IDLE:   wrHold <= hostWr;
        SUP_PFWAIT: wrHold <= wrHold && hostWr;
        default:    wrHold <= 1'b0;
      endcase
    end
  end

  always_comb begin
    gateCtl.blockAll = !((st == SUP_IDLE) || (st == SUP_PFWAIT));
    gateCtl.allowWe  = (st == SUP_IDLE) || ((st == SUP_PFWAIT) && wrHold && hostWr);
  end

  assign batSel = (st == SUP_BATTERY);
  assign wrProt = gateCtl.blockAll;

endmodule

// File: rtl/supply_guard_gate.sv
`timescale 1ns/1ps
module supply_guard_gate
  import supply_guard_pkg::*;
(
  input  gateCtl_t gateCtl,
  input  logic     hostCeN,
  input  logic     hostWeN,
  input  logic     hostOeN,
  output logic     ramCeN,
  output logic     ramWeN,
  output logic     ramOeN,
  output logic     outHiZ
);

  always_comb begin
    ramCeN = gateCtl.blockAll | hostCeN;
    ramOeN = gateCtl.blockAll | hostOeN;
    ramWeN = gateCtl.blockAll | !gateCtl.allowWe | hostWeN;
    outHiZ = gateCtl.blockAll | hostCeN | hostOeN | !hostWeN;
  end

endmodule

// File: rtl/supply_guard.sv
`timescale 1ns/1ps
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int PF_DLY_CYC  = 20000,
  parameter int REC_DLY_CYC = 16000000
) (
  input  logic clk,
  input  logic rstN,
  input  logic pfOk,
  input  logic soOk,
  input  logic hostCeN,
  input  logic hostWeN,
  input  logic hostOeN,
  output logic ramCeN,
  output logic ramWeN,
  output logic ramOeN,
  output logic batSel,
  output logic wrProt,
  output logic outHiZ
);

  gateCtl_t gateCtl;

  supply_guard_ctrl #(
    .PF_DLY_CYC (PF_DLY_CYC),
    .REC_DLY_CYC(REC_DLY_CYC)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pfOk   (pfOk),
    .soOk   (soOk),
    .hostCeN(hostCeN),
    .hostWeN(hostWeN),
    .gateCtl(gateCtl),
    .batSel (batSel),
    .wrProt (wrProt)
  );

  supply_guard_gate u_gate (
    .gateCtl(gateCtl),
    .hostCeN(hostCeN),
    .hostWeN(hostWeN),
    .hostOeN(hostOeN),
    .ramCeN (ramCeN),
    .ramWeN (ramWeN),
    .ramOeN (ramOeN),
    .outHiZ (outHiZ)
  );

endmodule

// File: rtl/supply_guard_chk.sv
`timescale 1ns/1ps
module supply_guard_chk #(
  parameter int PF_DLY_CYC  = 20000,
  parameter int REC_DLY_CYC = 16000000
) (
  input logic clk,
  input logic rstN,
  input logic pfOk,
  input logic soOk,
  input logic hostCeN,
  input logic hostOeN,
  input logic ramCeN,
  input logic ramWeN,
  input logic ramOeN,
  input logic batSel,
  input logic wrProt,
  input logic outHiZ
);

  localparam int GR_W = $clog2(REC_DLY_CYC + 1);

  logic [GR_W-1:0] goodRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                goodRun <= '0;
    else if (!(pfOk && soOk)) goodRun <= '0;
    else if (goodRun != GR_W'(REC_DLY_CYC)) goodRun <= goodRun + 1'b1;
  end

  // R4
  locked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrProt |-> (ramWeN && ramCeN && ramOeN && outHiZ));

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrProt |-> (ramCeN == hostCeN && ramOeN == hostOeN));

  // R5
  battery_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !soOk |=> batSel);

  // R10
  battery_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    batSel |-> wrProt);

  // R3
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrProt) |-> ($past(!pfOk) || $past(!soOk)));

  // R6
  release_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrProt) |-> (goodRun >= GR_W'(REC_DLY_CYC)));

endmodule

bind supply_guard supply_guard_chk #(
  .PF_DLY_CYC (PF_DLY_CYC),
  .REC_DLY_CYC(REC_DLY_CYC)
) u_chk (.*);

// File: tb/tb_supply_guard.sv
`timescale 1ns/1ps
module tb_supply_guard;

  localparam int PF  = 8;
  localparam int REC = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pfOk = 1'b1, soOk = 1'b1;
  logic hostCeN = 1'b1, hostWeN = 1'b1, hostOeN = 1'b1;
  logic ramCeN, ramWeN, ramOeN, batSel, wrProt, outHiZ;

  supply_guard #(.PF_DLY_CYC(PF), .REC_DLY_CYC(REC)) dut (
    .clk(clk), .rstN(rstN), .pfOk(pfOk), .soOk(soOk),
    .hostCeN(hostCeN), .hostWeN(hostWeN), .hostOeN(hostOeN),
    .ramCeN(ramCeN), .ramWeN(ramWeN), .ramOeN(ramOeN),
    .batSel(batSel), .wrProt(wrProt), .outHiZ(outHiZ)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [5:0] expQ[$];
  string      tagQ[$];

  wire [5:0] obs = {ramCeN, ramWeN, ramOeN, outHiZ, wrProt, batSel};

  function automatic void cmp(input logic [5:0] got, input logic [5:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b (ce we oe hiz prot bat)", tag, got, exp);
    end
  endfunction

  // monitor: one scoreboard entry per cycle, compared mid-cycle
  always @(negedge clk) begin
    if (expQ.size() > 0) cmp(obs, expQ.pop_front(), tagQ.pop_front());
  end

  // driver: apply inputs just after an edge, queue the expected outputs
  task automatic tick(input logic pf, input logic so, input logic ce, input logic we,
                      input logic oe, input logic prot, input logic bat,
                      input logic weOk, input string tag);
    logic [5:0] e;
    @(posedge clk); #1;
    pfOk = pf; soOk = so; hostCeN = ce; hostWeN = we; hostOeN = oe;
    e = {prot | ce, prot | !weOk | we, prot | oe, prot | ce | oe | !we, prot, bat};
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic hold(input int n, input logic pf, input logic so, input logic ce,
                      input logic we, input logic oe, input logic prot, input logic bat,
                      input logic weOk, input string tag);
    for (int i = 0; i < n; i++) tick(pf, so, ce, we, oe, prot, bat, weOk, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    cmp(obs, 6'b111110, "R1 locked during reset");
    rstN = 1'b1;
    hold(REC, 1, 1, 1, 1, 1, 1, 0, 1, "R1 hold after reset");
    tick(1, 1, 1, 1, 1, 0, 0, 1, "R1 released after reset hold");

    // R2 truth table while unlocked
    tick(1, 1, 1, 0, 0, 0, 0, 1, "R2 deselected");
    tick(1, 1, 0, 1, 1, 0, 0, 1, "R2 output disabled");
    tick(1, 1, 0, 1, 0, 0, 0, 1, "R2 read");
    tick(1, 1, 0, 0, 1, 0, 0, 1, "R2 write");
    tick(1, 1, 0, 0, 0, 0, 0, 1, "R2 write with oe low");
    tick(1, 1, 1, 1, 1, 0, 0, 1, "R2 idle");

    // R7 supply returns during protect delay
    tick(0, 1, 1, 1, 1, 0, 0, 1, "R7 sag seen");
    tick(0, 1, 0, 1, 0, 0, 0, 1, "R7 in delay, read allowed");
    tick(1, 1, 1, 1, 1, 0, 0, 1, "R7 supply back");
    hold(PF + 3, 1, 1, 0, 0, 1, 0, 0, 1, "R7 no lock, write passes");
    tick(1, 1, 1, 1, 1, 0, 0, 1, "R7 idle");

    // R3 / R8 delay length, in-flight write finishes, new write blocked
    tick(1, 1, 0, 0, 1, 0, 0, 1, "R8 write before sag");
    tick(0, 1, 0, 0, 1, 0, 0, 1, "R8 write at sag");
    tick(0, 1, 0, 0, 1, 0, 0, 1, "R8 in-flight write passes");
    tick(0, 1, 0, 1, 1, 0, 0, 1, "R8 write ends");
    hold(PF - 2, 0, 1, 0, 0, 1, 0, 0, 0, "R8 new write blocked");
    tick(0, 1, 0, 0, 1, 1, 0, 0, "R3 lock after delay");

    // R4 locked ignores host
    tick(0, 1, 0, 1, 0, 1, 0, 1, "R4 read ignored");
    tick(0, 1, 0, 0, 0, 1, 0, 1, "R4 write ignored");
    tick(0, 1, 1, 1, 1, 1, 0, 1, "R4 idle locked");

    // R5 battery switchover
    tick(0, 0, 0, 0, 1, 1, 0, 1, "R5 before switchover edge");
    hold(3, 0, 0, 0, 0, 1, 1, 1, 1, "R5 on battery");
    tick(0, 1, 0, 1, 0, 1, 1, 1, "R5 switchover flag back");
    tick(0, 1, 0, 1, 0, 1, 0, 1, "R5 off battery, still locked");

    // R11 recovery interrupted and restarted
    tick(1, 1, 1, 1, 1, 1, 0, 1, "R11 supply back");
    hold(3, 1, 1, 0, 0, 1, 1, 0, 1, "R11 recovering");
    tick(0, 1, 1, 1, 1, 1, 0, 1, "R11 sag during recovery");
    tick(0, 1, 1, 1, 1, 1, 0, 1, "R11 relocked");
    tick(1, 1, 1, 1, 1, 1, 0, 1, "R6 supply back");
    hold(REC, 1, 1, 0, 0, 1, 1, 0, 1, "R6 full recovery hold");
    tick(1, 1, 0, 0, 1, 0, 0, 1, "R6 released, write passes");

    // R10 invalid flag combination
    tick(1, 0, 1, 1, 1, 0, 0, 1, "R10 invalid seen");
    hold(3, 1, 0, 0, 0, 1, 1, 1, 1, "R10 safe state");
    tick(1, 1, 1, 1, 1, 1, 1, 1, "R10 flags valid again");
    hold(REC, 1, 1, 1, 1, 1, 1, 0, 1, "R10 recovery hold");
    tick(1, 1, 1, 1, 1, 0, 0, 1, "R10 released");

    // R9 write spanning whole delay is cut at expiry
    tick(1, 1, 0, 0, 1, 0, 0, 1, "R9 write before sag");
    tick(0, 1, 0, 0, 1, 0, 0, 1, "R9 write at sag");
    hold(PF, 0, 1, 0, 0, 1, 0, 0, 1, "R9 write held in delay");
    tick(0, 1, 0, 0, 1, 1, 0, 0, "R9 write cut at expiry");
    tick(1, 1, 1, 1, 1, 1, 0, 1, "R9 supply back");
    hold(REC, 1, 1, 1, 1, 1, 1, 0, 1, "R9 recovery");
    tick(1, 1, 1, 1, 1, 0, 0, 1, "R9 released");

    while (expQ.size() > 0) @(negedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule